// File: doc/BRIEF.md
# Stepwise Restoring Divider

This block performs unsigned division of a double-width dividend by a single-width divisor, split into separate caller-issued operations. A start operation takes the upper half of the dividend and a divisor, either from a register operand or an immediate operand. In one cycle it loads three internal registers: the partial quotient, the partial remainder and the saved divisor.

Step operations then feed in the lower half of the dividend together with a count of its bits not yet consumed. Each step shifts up to `STEP_BITS` further dividend bits into the remainder, most significant first, using restoring division. It returns the count of bits still unconsumed, so microcode can loop until that count reaches zero. Two read operations return the quotient and the remainder. Operand selection for the divisor or count works the same way in both start and step: `use_imm` chooses `imm_i` over `src_b_i`.

Top module: `stepwise_divider`

## Requirements
- R1: After reset every output is zero, and the quotient and remainder registers read back as zero.
- R2: A start (op code 0) with a non-zero divisor `d` (`imm_i` when `use_imm` is 1, else `src_b_i`) sets quotient to `src_a_i / d` and remainder to `src_a_i % d`, and saves `d` as the divisor.
- R3: A start whose divisor is zero, or a step that would consume bits while the saved divisor is zero, pulses `div_err_o` high for one cycle and leaves quotient, remainder and divisor unchanged.
- R4: A step (op code 1) with count `c` consumes `min(c, STEP_BITS)` bits of `src_a_i`, starting at bit position `c-1` and moving downward. For each bit, the remainder is shifted left with that bit appended. If the result is at least the divisor, the divisor is subtracted and a 1 enters the quotient's low end; otherwise a 0 enters.
- R5: A step returns on `result_o` the value `c` minus the bits it consumed. A count operand larger than `WIDTH` is treated as `WIDTH`.
- R6: A step with count zero leaves quotient, remainder and divisor unchanged and returns zero.
- R7: A step with `flag_req` set loads `ezf_o` with 1 when bits remain after that step and with 0 otherwise. Every other operation leaves `ezf_o` unchanged.
- R8: Op code 2 returns the quotient and op code 3 returns the remainder on `result_o`. Neither changes any internal register or `ezf_o`.
- R9: A start followed by steps that together consume all `WIDTH` low-half bits leaves quotient equal to the low `WIDTH` bits of `{high,low} / d` and remainder equal to `{high,low} % d`.
- R10: `result_valid_o` is high for exactly the cycle after a step or read operation is accepted. It stays low after a start or when no operation is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 2 | 0 start, 1 step, 2 read quotient, 3 read remainder |
| use_imm | input | 1 | Take divisor or count from `imm_i` instead of `src_b_i` |
| flag_req | input | 1 | Step updates `ezf_o` |
| src_a_i | input | WIDTH | Dividend high half (start) or low half (step) |
| src_b_i | input | WIDTH | Register divisor or count |
| imm_i | input | WIDTH | Immediate divisor or count |
| result_o | output | WIDTH | Remaining count or unloaded value |
| result_valid_o | output | 1 | `result_o` holds a new value |
| ezf_o | output | 1 | Bits-remaining flag |
| div_err_o | output | 1 | Zero-divisor pulse |

## Verification
Full divisions run across a set of dividend and divisor pairs: small dividends with only a low half, dividends with a non-zero upper half, a quotient wider than `WIDTH` that must truncate, a divisor of one, and a divisor with only its top bit set. Together these separate correct restoring subtraction from off-by-one bit ordering and remainder overflow. The divisor source alternates between register and immediate to show that both operand paths work. Directed cases cover a count that is not a multiple of `STEP_BITS`, an oversize count, a zero count, zero divisors at start and at step, and flag updates with and without `flag_req`. These cases isolate the count arithmetic from the datapath.

// File: rtl/stepwise_divider.sv
module stepwise_divider #(
  parameter int WIDTH     = 32,
  parameter int STEP_BITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic             use_imm,
  input  logic             flag_req,
  input  logic [WIDTH-1:0] src_a_i,
  input  logic [WIDTH-1:0] src_b_i,
  input  logic [WIDTH-1:0] imm_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_valid_o,
  output logic             ezf_o,
  output logic             div_err_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [1:0] OP_START = 2'd0, OP_STEP = 2'd1, OP_RDQ = 2'd2, OP_RDR = 2'd3;
  localparam logic [CW-1:0] CNT_MAX = CW'(WIDTH);
  localparam logic [CW-1:0] STEP_MAX = CW'(STEP_BITS);

  logic [WIDTH-1:0] quo_q, rem_q, dvs_q;
  logic [WIDTH-1:0] opnd;
  logic [CW-1:0]    cnt, take, remain;
  logic [WIDTH-1:0] nq, nr;
  logic [CW-1:0]    idx;
  logic [WIDTH:0]   part;
  logic [WIDTH-1:0] shifted;

  assign opnd   = use_imm ? imm_i : src_b_i;
  assign cnt    = (opnd > WIDTH'(WIDTH)) ? CNT_MAX : opnd[CW-1:0];
  assign take   = (cnt > STEP_MAX) ? STEP_MAX : cnt;
  assign remain = cnt - take;

  always_comb begin
    nq = quo_q;
    nr = rem_q;
    idx = '0;
    part = '0;
    shifted = '0;
    for (int i = 0; i < STEP_BITS; i++) begin
      if (CW'(i) < take) begin
        idx = cnt - CW'(i) - CW'(1);
        shifted = src_a_i >> idx;
        part = {nr, shifted[0]};
        if (part >= {1'b0, dvs_q}) begin
          nr = WIDTH'(part - {1'b0, dvs_q});
          nq = {nq[WIDTH-2:0], 1'b1};
        end else begin
          nr = part[WIDTH-1:0];
          nq = {nq[WIDTH-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      result_o <= '0;
      result_valid_o <= 1'b0;
      ezf_o <= 1'b0;
      div_err_o <= 1'b0;
    end else begin
      result_valid_o <= 1'b0;
      div_err_o <= 1'b0;
      if (op_valid) begin
        case (op_code)
          OP_START: begin
            if (opnd == '0) begin
              div_err_o <= 1'b1;
            end else begin
              quo_q <= src_a_i / opnd;
              rem_q <= src_a_i % opnd;
              dvs_q <= opnd;
            end
          end
          OP_STEP: begin
            result_o <= WIDTH'(remain);
            result_valid_o <= 1'b1;
            if (flag_req) ezf_o <= (remain != '0);
            if (take != '0) begin
              if (dvs_q == '0) begin
                div_err_o <= 1'b1;
              end else begin
                quo_q <= nq;
                rem_q <= nr;
              end
            end
          end
          OP_RDQ: begin
            result_o <= quo_q;
            result_valid_o <= 1'b1;
          end
          default: begin
            result_o <= rem_q;
            result_valid_o <= 1'b1;
          end
        endcase
      end
    end
  end

  p_err_holds_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_err_o |-> (quo_q == $past(quo_q) && rem_q == $past(rem_q) && dvs_q == $past(dvs_q)));

  p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_q != '0) |-> (rem_q < dvs_q));

  p_zero_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_STEP && cnt == '0) |=> ($stable(quo_q) && $stable(rem_q) && $stable(dvs_q)));

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code == OP_STEP && flag_req) |=> $stable(ezf_o));

  p_count_not_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_STEP) |=> (result_o <= WIDTH'(CNT_MAX)));

  p_valid_after_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $past(op_valid && op_code != OP_START));
endmodule

// File: tb/stepwise_divider_test.sv
`timescale 1ns/1ps
module stepwise_divider_test;
  localparam int W = 16;
  localparam int SB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic use_imm = 1'b0;
  logic flag_req = 1'b0;
  logic [W-1:0] src_a_i = '0, src_b_i = '0, imm_i = '0;
  logic [W-1:0] result_o;
  logic result_valid_o, ezf_o, div_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  stepwise_divider #(.WIDTH(W), .STEP_BITS(SB)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .use_imm(use_imm), .flag_req(flag_req), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .imm_i(imm_i), .result_o(result_o),
    .result_valid_o(result_valid_o), .ezf_o(ezf_o), .div_err_o(div_err_o));

  // {high, low, divisor}
  localparam logic [47:0] VEC [6] = '{
    {16'h0000, 16'd100,  16'd7},
    {16'h0003, 16'h1234, 16'd10},
    {16'hFFFF, 16'hFFFF, 16'hFFFF},
    {16'h0005, 16'h0000, 16'd3},
    {16'h0ABC, 16'h8001, 16'd1},
    {16'h7FFF, 16'hC3A5, 16'h8000}
  };

  task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic imm_sel, input logic fr,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; use_imm = imm_sel; flag_req = fr;
    src_a_i = a;
    if (imm_sel) begin imm_i = b; src_b_i = 16'hDEAD; end
    else begin src_b_i = b; imm_i = 16'hBEEF; end
    @(negedge clk);
    op_valid = 1'b0; flag_req = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] dividend;
    logic [W-1:0] cnt, exp_q, exp_r, prev_q;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(result_o, '0, "R1 result");
    check({15'd0, result_valid_o}, '0, "R1 valid");
    check({15'd0, ezf_o}, '0, "R1 flag");
    check({15'd0, div_err_o}, '0, "R1 err");
    rst_n = 1'b1;
    issue(2'd2, 1'b0, 1'b0, '0, '0);
    check(result_o, '0, "R1 quotient after reset");
    issue(2'd3, 1'b0, 1'b0, '0, '0);
    check(result_o, '0, "R1 remainder after reset");

    // R3 step with zero saved divisor
    issue(2'd1, 1'b0, 1'b0, 16'hFFFF, 16'd4);
    check({15'd0, div_err_o}, 16'd1, "R3 step zero divisor err");
    issue(2'd2, 1'b0, 1'b0, '0, '0);
    check(result_o, '0, "R3 step zero divisor quotient held");

    // R9/R2/R4/R5 full divisions from table
    foreach (VEC[k]) begin
      dividend = {VEC[k][47:32], VEC[k][31:16]};
      exp_q = W'(dividend / {16'd0, VEC[k][15:0]});
      exp_r = W'(dividend % {16'd0, VEC[k][15:0]});
      issue(2'd0, k[0], 1'b0, VEC[k][47:32], VEC[k][15:0]);
      check({15'd0, result_valid_o}, '0, "R10 no valid after start");
      issue(2'd2, 1'b0, 1'b0, '0, '0);
      check(result_o, VEC[k][47:32] / VEC[k][15:0], "R2 start quotient");
      issue(2'd3, 1'b0, 1'b0, '0, '0);
      check(result_o, VEC[k][47:32] % VEC[k][15:0], "R2 start remainder");
      cnt = 16'd16;
      while (cnt != 0) begin
        issue(2'd1, ~k[0], 1'b0, VEC[k][31:16], cnt);
        check({15'd0, result_valid_o}, 16'd1, "R10 valid after step");
        check(result_o, (cnt > SB) ? cnt - SB : 16'd0, "R5 remaining count");
        cnt = (cnt > SB) ? cnt - SB : 16'd0;
      end
      issue(2'd2, 1'b0, 1'b0, '0, '0);
      check(result_o, exp_q, "R9 final quotient");
      issue(2'd3, 1'b0, 1'b0, '0, '0);
      check(result_o, exp_r, "R9 final remainder");
    end

    // R4 single step partial: top nibble 1111 divided by 3
    issue(2'd0, 1'b1, 1'b0, 16'd0, 16'd3);
    issue(2'd1, 1'b0, 1'b1, 16'hF000, 16'd16);
    check(result_o, 16'd12, "R5 step from 16");
    check({15'd0, ezf_o}, 16'd1, "R7 flag bits remain");
    issue(2'd2, 1'b0, 1'b0, '0, '0);
    check(result_o, 16'd5, "R4 partial quotient");
    check({15'd0, ezf_o}, 16'd1, "R8 read keeps flag");
    issue(2'd3, 1'b0, 1'b0, '0, '0);
    check(result_o, 16'd0, "R4 partial remainder");

    // R4 count not a multiple of step size: 3 bits 101 from position 2
    issue(2'd0, 1'b0, 1'b0, 16'd0, 16'd2);
    issue(2'd1, 1'b1, 1'b1, 16'h0005, 16'd3);
    check(result_o, 16'd0, "R5 short count to zero");
    check({15'd0, ezf_o}, 16'd0, "R7 flag no bits remain");
    issue(2'd2, 1'b0, 1'b0, '0, '0);
    check(result_o, 16'd2, "R4 short step quotient");
    issue(2'd3, 1'b0, 1'b0, '0, '0);
    check(result_o, 16'd1, "R4 short step remainder");

    // R7 step without flag request leaves flag
    issue(2'd1, 1'b0, 1'b0, 16'h0000, 16'd9);
    check(result_o, 16'd5, "R5 count 9");
    check({15'd0, ezf_o}, 16'd0, "R7 flag held without request");

    // R5 oversize count clamps to width
    issue(2'd0, 1'b0, 1'b0, 16'd0, 16'd5);
    issue(2'd1, 1'b0, 1'b0, 16'hFFFF, 16'd40);
    check(result_o, 16'd12, "R5 oversize count");

    // R6 zero count
    issue(2'd2, 1'b0, 1'b0, '0, '0);
    prev_q = result_o;
    issue(2'd1, 1'b0, 1'b1, 16'hFFFF, 16'd0);
    check(result_o, 16'd0, "R6 zero count result");
    check({15'd0, ezf_o}, 16'd0, "R7 flag zero count");
    issue(2'd2, 1'b0, 1'b0, '0, '0);
    check(result_o, prev_q, "R6 quotient unchanged");

    // R3 zero divisor at start
    issue(2'd0, 1'b1, 1'b0, 16'd77, 16'd0);
    check({15'd0, div_err_o}, 16'd1, "R3 start zero divisor err");
    @(negedge clk);
    check({15'd0, div_err_o}, 16'd0, "R3 err single pulse");
    issue(2'd2, 1'b0, 1'b0, '0, '0);
    check(result_o, prev_q, "R3 quotient unchanged");

    // R10 idle cycle
    @(negedge clk);
    check({15'd0, result_valid_o}, 16'd0, "R10 idle no valid");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule